// File: doc/BRIEF.md
# Sequential Shift-Subtract Divider with Position Marker

This block divides an unsigned 22-bit dividend by an unsigned 11-bit divisor. It does the work one bit per clock, so it needs only one subtractor and one comparator instead of a wide array divider. It suits control datapaths where a quotient is needed only now and then, and where logic area matters more than latency.

All working registers are as wide as the dividend. After a start, the divisor is shifted left until its leading one sits under the leading one of the dividend. It is then walked back to the right, with one compare-and-subtract at each position. A separate marker register starts as all ones and takes a zero into its low end on every alignment shift. The lowest set bit of the marker therefore always shows where the divisor's least significant bit currently sits. The marker decides when the division ends; there is no iteration counter.

Two cases finish in a single cycle and never raise busy:
- A zero divisor sets a flag and returns a saturated quotient.
- A dividend smaller than the divisor returns a zero quotient, with the dividend as the remainder.

Top module: `sdiv_pivot`

## Requirements
- R1: While `rst` is high and after it is released, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all 0 until the first accepted start.
- R2: A `start` seen while `busy` is 0, with a nonzero divisor not greater than the dividend, captures both operands and clears the quotient. `busy` is 1 in the cycle after that edge.
- R3: For every nonzero divisor, the completed result has `quotient` equal to floor(dividend / divisor) and `remainder` equal to dividend mod divisor.
- R4: When the divisor is nonzero and greater than the dividend, `done` is 1 in the cycle after the start edge and `busy` is never raised. `quotient` is 0 and `remainder` equals the dividend.
- R5: When the divisor is 0, `done` and `div_by_zero` are 1 in the cycle after the start edge and `busy` is never raised. `quotient` is all ones (22'h3FFFFF) and `remainder` is 0.
- R6: `div_by_zero` is cleared by the next accepted start with a nonzero divisor, and stays 0 through that operation's completion.
- R7: For a dividend not less than a nonzero divisor, let k be the bit index of the dividend's leading one minus that of the divisor's leading one. Then `busy` stays 1 for exactly 2k+1 cycles: k alignment shifts followed by k+1 compare steps.
- R8: `done` is high for exactly one cycle, at the point where `busy` has returned to 0. While `busy` is 0 and no start is applied, `quotient`, `remainder` and `div_by_zero` hold their values.
- R9: A `start` applied while `busy` is 1 is ignored. The running division completes with the operands captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division; accepted only while idle |
| dividend | input | 22 | Unsigned dividend, sampled at the accepted start |
| divisor | input | 11 | Unsigned divisor, sampled at the accepted start |
| busy | output | 1 | A multi-cycle division is in progress |
| done | output | 1 | One-cycle pulse when a result becomes valid |
| div_by_zero | output | 1 | The last accepted operation had a zero divisor |
| quotient | output | 22 | Quotient of the last completed operation |
| remainder | output | 11 | Remainder of the last completed operation |

## Verification
The assertions check several things on every cycle:
- The marker always has the shape ones-above-zeros.
- The divisor register is never zero during a compare step.
- The remainder is below the divisor whenever a normal result completes.
- `done` is a single-cycle pulse that occurs only while idle.
- Idle outputs hold steady.
- A raised zero flag always comes with a saturated quotient.

Only the bench scenarios can show the rest. These are the exact quotient and remainder values, the 2k+1 busy length for each operand spread, the single-cycle exits for a zero divisor and for a small dividend, the clearing of the flag, and that a start arriving mid-operation leaves the result unchanged.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_STEP
  } sdiv_state_e;

  typedef enum logic [2:0] {
    CMD_HOLD,
    CMD_LOAD,
    CMD_ZERO,
    CMD_SHORT,
    CMD_SHL,
    CMD_STEP
  } sdiv_cmd_e;

endpackage

// File: rtl/sdiv_stepper.sv
module sdiv_stepper #(
  parameter int W = 22
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dsr_i,
  output logic         ge_o,
  output logic [W-1:0] diff_o,
  output logic         room_o
);

  // smear[i] is 1 when the remainder has any set bit at position i or above
  logic [W-1:0] smear;
  logic [W-1:0] dsr_up;

  assign smear[W-1] = rem_i[W-1];

  genvar gi;
  generate
    for (gi = W - 2; gi >= 0; gi--) begin : g_smear
      assign smear[gi] = smear[gi+1] | rem_i[gi];
    end
  endgenerate

  assign dsr_up = dsr_i << 1;

  // another left shift keeps the divisor's leading one at or below the remainder's
  assign room_o = !dsr_i[W-1] && ((dsr_up & ~smear) == '0);
  assign ge_o   = (rem_i >= dsr_i);
  assign diff_o = rem_i - dsr_i;

endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int DD_W = 22,
  parameter int DV_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DD_W-1:0]   dividend,
  input  logic [DV_W-1:0]   divisor,
  input  logic              room,
  input  logic              marker_zero,
  output sdiv_state_e       state,
  output sdiv_cmd_e         cmd,
  output logic              done
);

  sdiv_state_e state_nxt;
  logic        fin;
  logic [DD_W-1:0] dv_wide;

  assign dv_wide = DD_W'(divisor);

  always_comb begin
    cmd       = CMD_HOLD;
    state_nxt = state;
    fin       = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (divisor == '0) begin
            cmd = CMD_ZERO;
            fin = 1'b1;
          end else if (dv_wide > dividend) begin
            cmd = CMD_SHORT;
            fin = 1'b1;
          end else begin
            cmd       = CMD_LOAD;
            state_nxt = ST_ALIGN;
          end
        end
      end
      ST_ALIGN: begin
        if (room) begin
          cmd = CMD_SHL;
        end else begin
          cmd = CMD_STEP;
          if (marker_zero) begin
            state_nxt = ST_IDLE;
            fin       = 1'b1;
          end else begin
            state_nxt = ST_STEP;
          end
        end
      end
      ST_STEP: begin
        cmd = CMD_STEP;
        if (marker_zero) begin
          state_nxt = ST_IDLE;
          fin       = 1'b1;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nxt;
      done  <= fin;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == ST_IDLE));

  // R9
  busy_no_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (cmd != CMD_LOAD && cmd != CMD_ZERO && cmd != CMD_SHORT));

endmodule

// File: rtl/sdiv_regs.sv
module sdiv_regs
  import sdiv_pkg::*;
#(
  parameter int W    = 22,
  parameter int DV_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  sdiv_cmd_e       cmd,
  input  logic [W-1:0]    dividend,
  input  logic [DV_W-1:0] divisor,
  input  logic            ge,
  input  logic [W-1:0]    diff,
  output logic [W-1:0]    rem_q,
  output logic [W-1:0]    dsr_q,
  output logic [W-1:0]    quo_q,
  output logic [W-1:0]    piv_q,
  output logic            dz_q
);

  logic [W-1:0] dv_wide;
  assign dv_wide = W'(divisor);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      dsr_q <= '0;
      quo_q <= '0;
      piv_q <= '1;
      dz_q  <= 1'b0;
    end else begin
      case (cmd)
        CMD_LOAD: begin
          rem_q <= dividend;
          dsr_q <= dv_wide;
          quo_q <= '0;
          piv_q <= '1;
          dz_q  <= 1'b0;
        end
        CMD_ZERO: begin
          rem_q <= '0;
          dsr_q <= '0;
          quo_q <= '1;
          piv_q <= '1;
          dz_q  <= 1'b1;
        end
        CMD_SHORT: begin
          rem_q <= dividend;
          dsr_q <= dv_wide;
          quo_q <= '0;
          piv_q <= '1;
          dz_q  <= 1'b0;
        end
        CMD_SHL: begin
          dsr_q <= dsr_q << 1;
          piv_q <= piv_q << 1;
        end
        CMD_STEP: begin
          if (ge) rem_q <= diff;
          quo_q <= {quo_q[W-2:0], ge};
          if (!piv_q[0]) begin
            dsr_q <= dsr_q >> 1;
            piv_q <= {1'b1, piv_q[W-1:1]};
          end
        end
        default: ;
      endcase
    end
  end

  // R7
  piv_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (((~piv_q) & ((~piv_q) + 1'b1)) == '0));

  // R3
  step_dsr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STEP) |-> (dsr_q != '0));

  // R5
  dz_sat_chk: assert property (@(posedge clk) disable iff (rst)
    dz_q |-> (quo_q == '1));

endmodule

// File: rtl/sdiv_pivot.sv
module sdiv_pivot
  import sdiv_pkg::*;
#(
  parameter int DIVIDEND_W = 22,
  parameter int DIVISOR_W  = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [DIVIDEND_W-1:0] dividend,
  input  logic [DIVISOR_W-1:0]  divisor,
  output logic                  busy,
  output logic                  done,
  output logic                  div_by_zero,
  output logic [DIVIDEND_W-1:0] quotient,
  output logic [DIVISOR_W-1:0]  remainder
);

  localparam int W = DIVIDEND_W;

  sdiv_state_e  state;
  sdiv_cmd_e    cmd;
  logic         ge;
  logic         room;
  logic [W-1:0] diff;
  logic [W-1:0] rem_q;
  logic [W-1:0] dsr_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] piv_q;
  logic         dz_q;

  sdiv_ctrl #(.DD_W(W), .DV_W(DIVISOR_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .room        (room),
    .marker_zero (piv_q[0]),
    .state       (state),
    .cmd         (cmd),
    .done        (done)
  );

  sdiv_stepper #(.W(W)) u_step (
    .rem_i  (rem_q),
    .dsr_i  (dsr_q),
    .ge_o   (ge),
    .diff_o (diff),
    .room_o (room)
  );

  sdiv_regs #(.W(W), .DV_W(DIVISOR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .dividend (dividend),
    .divisor  (divisor),
    .ge       (ge),
    .diff     (diff),
    .rem_q    (rem_q),
    .dsr_q    (dsr_q),
    .quo_q    (quo_q),
    .piv_q    (piv_q),
    .dz_q     (dz_q)
  );

  assign busy        = (state != ST_IDLE);
  assign div_by_zero = dz_q;
  assign quotient    = quo_q;
  assign remainder   = rem_q[DIVISOR_W-1:0];

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

  // R3
  rem_below_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !div_by_zero) |-> (rem_q < dsr_q));

  // R4
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: tb/sdiv_pivot_tb.sv
`timescale 1ns/1ps
module sdiv_pivot_tb;

  localparam int DD_W = 22;
  localparam int DV_W = 11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [DD_W-1:0] dividend = '0;
  logic [DV_W-1:0] divisor = '0;
  logic            busy, done, div_by_zero;
  logic [DD_W-1:0] quotient;
  logic [DV_W-1:0] remainder;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  sdiv_pivot u_dut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_by_zero(div_by_zero),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lead_one(input logic [31:0] v);
    int p = -1;
    for (int i = 0; i < 32; i++) if (v[i]) p = i;
    return p;
  endfunction

  task automatic run_op(input logic [DD_W-1:0] dd, input logic [DV_W-1:0] dv, input bit poke);
    logic [DD_W-1:0] exp_q;
    logic [DV_W-1:0] exp_r;
    int exp_busy, cnt, guard;
    logic [DD_W-1:0] held_q;
    logic [DV_W-1:0] held_r;
    logic held_z;
    if (dv == 0) begin
      exp_q = '1; exp_r = '0; exp_busy = 0;
    end else begin
      exp_q = dd / DD_W'(dv);
      exp_r = DV_W'(dd % DD_W'(dv));
      exp_busy = (DD_W'(dv) > dd) ? 0 : 2 * (lead_one(32'(dd)) - lead_one(32'(dv))) + 1;
    end
    @(negedge clk);
    start = 1'b1; dividend = dd; divisor = dv;
    @(negedge clk);
    start = 1'b0;
    dividend = DD_W'($urandom); divisor = DV_W'($urandom);
    if (exp_busy > 0) check("R2 busy after start", 64'(busy), 64'd1);
    if (exp_busy > 0 && dv != 0) check("R6 flag clear", 64'(div_by_zero), 64'd0);
    cnt = 0; guard = 0;
    while (!done && guard < 400) begin
      if (busy) cnt++;
      if (poke && busy && cnt == 1) begin
        start = 1'b1; dividend = ~dd; divisor = dv + 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    if (guard >= 400) check("watchdog op", 64'd1, 64'd0);
    check(poke ? "R9 quotient" : "R3 quotient", 64'(quotient), 64'(exp_q));
    check(poke ? "R9 remainder" : "R3 remainder", 64'(remainder), 64'(exp_r));
    check("R5 flag", 64'(div_by_zero), 64'(dv == 0));
    if (dv == 0) check("R5 busy len", 64'(cnt), 64'd0);
    else if (exp_busy == 0) check("R4 busy len", 64'(cnt), 64'd0);
    else check("R7 busy len", 64'(cnt), 64'(exp_busy));
    check("R8 not busy at done", 64'(busy), 64'd0);
    held_q = quotient; held_r = remainder; held_z = div_by_zero;
    @(negedge clk);
    check("R8 done pulse", 64'(done), 64'd0);
    check("R8 hold q", 64'(quotient), 64'(held_q));
    check("R8 hold r", 64'(remainder), 64'(held_r));
    check("R8 hold z", 64'(div_by_zero), 64'(held_z));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 busy in reset", 64'(busy), 64'd0);
    check("R1 done in reset", 64'(done), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 flag", 64'(div_by_zero), 64'd0);
    check("R1 quotient", 64'(quotient), 64'd0);
    check("R1 remainder", 64'(remainder), 64'd0);

    // directed corners
    run_op(22'd1, 11'd1, 1'b0);          // R7 k=0
    run_op(22'h3FFFFF, 11'd1, 1'b0);     // R7 k=21
    run_op(22'h3FFFFF, 11'd2047, 1'b0);
    run_op(22'd0, 11'd5, 1'b0);          // R4
    run_op(22'd2046, 11'd2047, 1'b0);    // R4
    run_op(22'd12345, 11'd0, 1'b0);      // R5
    run_op(22'd100, 11'd7, 1'b0);        // R6 flag clears after zero divisor
    run_op(22'd2047, 11'd2047, 1'b0);
    run_op(22'h200000, 11'd3, 1'b0);
    run_op(22'd1024, 11'd1023, 1'b0);
    run_op(22'd0, 11'd0, 1'b0);          // R5
    run_op(22'h3ABCDE, 11'd77, 1'b1);    // R9
    run_op(22'd999, 11'd1, 1'b1);        // R9

    for (int n = 0; n < 400; n++) begin
      logic [DD_W-1:0] a;
      logic [DV_W-1:0] b;
      int wa, wb;
      wa = $urandom_range(1, DD_W);
      wb = $urandom_range(1, DV_W);
      a = DD_W'($urandom) & DD_W'((64'd1 << wa) - 1);
      b = DV_W'($urandom) & DV_W'((64'd1 << wb) - 1);
      if ($urandom_range(0, 19) == 0) b = '0;
      run_op(a, b, ($urandom_range(0, 7) == 0));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule